// File: doc/BRIEF.md
# Single-Shot Bus Access Proxy

This block is a memory-mapped slave that carries out one bus access on a system bus for software. The access uses an initiator identity and a security domain that software picks. Software loads the target address into one register and, for a write, the payload into a second register. It then writes a control word. That control write launches the access. The control word selects the direction, the byte lanes, the domain and a 6-bit master identity. All of these are presented on a simple valid/ready master port.

Software gets no done flag. For a read, it preloads the data register with a marker word, launches the read, and polls the data register until the marker has been overwritten by the returned word. An external disable input blocks the launch of reads but not writes. While an access is in flight, further register writes are dropped, so the request cannot be altered mid-flight.

Top module: `mmio_bus_proxy`

## Requirements
- R1: After reset the address, data and control registers read as zero and no request is presented (`m_req_valid` low).
- R2: Slave byte offset 0x0 holds the target address and 0x4 holds the data word. Offset 0x8 holds the control word. Any other offset reads as zero.
- R3: A write to offset 0x8 while idle presents a request (`m_req_valid` high) from the next cycle, unless R8 suppresses it.
- R4: The request carries the address register on `m_addr` and the data register on `m_wdata`. Control bit 0 drives `m_write` (1 = write, 0 = read). Bits 2:1 drive `m_domain` (0 secure, 1 alternate, 2 non-secure). Bits 6:3 drive `m_strb`, with bit 3 mapping to lane 0 (bits 7:0) and bit 6 to lane 3. Bits 30:25 drive `m_master_id`.
- R5: Control bit 31 always reads as zero, whatever was written to it.
- R6: While `m_req_valid` is high and `m_req_ready` is low, the request stays asserted and every request field holds its value.
- R7: A response to a read overwrites the data register with `m_rsp_rdata`. A response to a write leaves the data register unchanged.
- R8: While `rd_disable` is high, a control write with bit 0 clear presents no request and leaves the data register unchanged. A control write with bit 0 set still launches.
- R9: From launch until the response, writes to all three registers are ignored. No second request is presented, and the address and control registers keep their values.
- R10: Each launch produces exactly one request. After the handshake, `m_req_valid` stays low until a later control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_disable | input | 1 | Blocks launch of read accesses |
| sl_we | input | 1 | Slave register write strobe |
| sl_addr | input | REG_AW | Slave register byte offset (write and read) |
| sl_wdata | input | DATA_W | Slave write data |
| sl_rdata | output | DATA_W | Slave read data for `sl_addr` |
| m_req_valid | output | 1 | Master request valid |
| m_req_ready | input | 1 | Master request accepted |
| m_addr | output | DATA_W | Target address |
| m_wdata | output | DATA_W | Write payload |
| m_strb | output | DATA_W/8 | Byte lane enables |
| m_write | output | 1 | 1 = write, 0 = read |
| m_domain | output | 2 | Security domain select |
| m_master_id | output | 6 | Impersonated initiator identity |
| m_rsp_valid | input | 1 | Response pulse |
| m_rsp_rdata | input | DATA_W | Read data returned with the response |

## Verification
The bench holds `m_req_ready` low for many cycles while it rewrites the address, data and control registers. A design that does not lock its registers would corrupt the pending request or launch a second request, which the request monitor reports as a field change or an unexpected request. Reads are polled against a preloaded marker word, and a read issued under `rd_disable` is checked for both a missing request and an untouched data word. A design that gates the wrong direction, or that captures the response of a write, shows a wrong polled value. Strobe, domain and identity patterns are chosen so that a swapped lane order or a misplaced field shows up in the compared request.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
   localparam int CTRL_W      = 32;
   localparam int DOM_W       = 2;
   localparam int ID_W        = 6;
   localparam int LANE_N      = 4;
   localparam int CTRL_WR_BIT = 0;
   localparam int CTRL_DOM_LO = 1;
   localparam int CTRL_STB_LO = 3;
   localparam int CTRL_ID_LO  = 25;
   localparam int CTRL_RO_BIT = 31;
   localparam logic [CTRL_W-1:0] CTRL_RO_MASK = CTRL_W'(1) << CTRL_RO_BIT;

   localparam int OFF_ADDR = 0;
   localparam int OFF_DATA = 4;
   localparam int OFF_CTRL = 8;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_RSP  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/mbp_regs.sv
module mbp_regs
   import mbp_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_AW    = 4,
   parameter bit REG_RDATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lock,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] cap_data,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic              f_write,
   output logic [DOM_W-1:0]  f_dom,
   output logic [LANE_N-1:0] f_strb,
   output logic [ID_W-1:0]   f_id,
   output logic              ctrl_acc
);
   localparam logic [REG_AW-1:0] A_ADDR = REG_AW'(OFF_ADDR);
   localparam logic [REG_AW-1:0] A_DATA = REG_AW'(OFF_DATA);
   localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFF_CTRL);

   logic              hit_addr, hit_data, hit_ctrl;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] rd_mux;

   assign hit_addr = (addr == A_ADDR);
   assign hit_data = (addr == A_DATA);
   assign hit_ctrl = (addr == A_CTRL);
   assign ctrl_acc = we && hit_ctrl && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (we && hit_addr && !lock) begin
         addr_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (cap_en) begin
         data_q <= cap_data;
      end else if (we && hit_data && !lock) begin
         data_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_acc) begin
         ctrl_q <= wdata & ~CTRL_RO_MASK;
      end
   end

   assign f_write = ctrl_q[CTRL_WR_BIT];
   assign f_dom   = ctrl_q[CTRL_DOM_LO +: DOM_W];
   assign f_strb  = ctrl_q[CTRL_STB_LO +: LANE_N];
   assign f_id    = ctrl_q[CTRL_ID_LO +: ID_W];

   always_comb begin
      rd_mux = '0;
      if (hit_addr) rd_mux = addr_q;
      if (hit_data) rd_mux = data_q;
      if (hit_ctrl) rd_mux = ctrl_q;
   end

   generate
      if (REG_RDATA) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/mbp_seq.sv
module mbp_seq
   import mbp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_acc,
   input  logic new_write,
   input  logic rd_disable,
   input  logic req_ready,
   input  logic rsp_valid,
   output logic req_valid,
   output logic busy,
   output logic cap_en
);
   seq_state_e st_q, st_d;
   logic       op_wr_q;
   logic       launch;

   assign launch = ctrl_acc && (new_write || !rd_disable);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQ_IDLE: if (launch)    st_d = SQ_REQ;
         SQ_REQ:  if (req_ready) st_d = SQ_RSP;
         SQ_RSP:  if (rsp_valid) st_d = SQ_IDLE;
         default:                st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         op_wr_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (launch) op_wr_q <= new_write;
      end
   end

   assign req_valid = (st_q == SQ_REQ);
   assign busy      = (st_q != SQ_IDLE);
   assign cap_en    = (st_q == SQ_RSP) && rsp_valid && !op_wr_q;
endmodule

// File: rtl/mmio_bus_proxy.sv
module mmio_bus_proxy
   import mbp_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_AW    = 4,
   parameter bit REG_RDATA = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_disable,
   input  logic                   sl_we,
   input  logic [REG_AW-1:0]      sl_addr,
   input  logic [DATA_W-1:0]      sl_wdata,
   output logic [DATA_W-1:0]      sl_rdata,
   output logic                   m_req_valid,
   input  logic                   m_req_ready,
   output logic [DATA_W-1:0]      m_addr,
   output logic [DATA_W-1:0]      m_wdata,
   output logic [DATA_W/8-1:0]    m_strb,
   output logic                   m_write,
   output logic [DOM_W-1:0]       m_domain,
   output logic [ID_W-1:0]        m_master_id,
   input  logic                   m_rsp_valid,
   input  logic [DATA_W-1:0]      m_rsp_rdata
);
   generate
      if (DATA_W != CTRL_W) begin : g_bad_width
         $error("mmio_bus_proxy: DATA_W must equal the control word width");
      end
      if (REG_AW < 4) begin : g_bad_aw
         $error("mmio_bus_proxy: REG_AW too small for three word registers");
      end
   endgenerate

   logic busy, cap_en, ctrl_acc;
   logic [LANE_N-1:0] strb_w;

   mbp_regs #(
      .DATA_W   (DATA_W),
      .REG_AW   (REG_AW),
      .REG_RDATA(REG_RDATA)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (sl_we),
      .addr    (sl_addr),
      .wdata   (sl_wdata),
      .lock    (busy),
      .cap_en  (cap_en),
      .cap_data(m_rsp_rdata),
      .rdata   (sl_rdata),
      .addr_q  (m_addr),
      .data_q  (m_wdata),
      .f_write (m_write),
      .f_dom   (m_domain),
      .f_strb  (strb_w),
      .f_id    (m_master_id),
      .ctrl_acc(ctrl_acc)
   );

   assign m_strb = strb_w;

   mbp_seq seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_acc  (ctrl_acc),
      .new_write (sl_wdata[CTRL_WR_BIT]),
      .rd_disable(rd_disable),
      .req_ready (m_req_ready),
      .rsp_valid (m_rsp_valid),
      .req_valid (m_req_valid),
      .busy      (busy),
      .cap_en    (cap_en)
   );
endmodule

// File: rtl/mbp_checker.sv
module mbp_checker
   import mbp_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_AW    = 4,
   parameter bit REG_RDATA = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_disable,
   input logic                sl_we,
   input logic [REG_AW-1:0]   sl_addr,
   input logic [DATA_W-1:0]   sl_wdata,
   input logic [DATA_W-1:0]   sl_rdata,
   input logic                m_req_valid,
   input logic                m_req_ready,
   input logic [DATA_W-1:0]   m_addr,
   input logic [DATA_W-1:0]   m_wdata,
   input logic [DATA_W/8-1:0] m_strb,
   input logic                m_write,
   input logic [DOM_W-1:0]    m_domain,
   input logic [ID_W-1:0]     m_master_id,
   input logic                m_rsp_valid
);
   localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFF_CTRL);

   logic outst_q;
   logic idle;
   logic ctrl_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       outst_q <= 1'b0;
      else if (m_req_valid && m_req_ready) outst_q <= 1'b1;
      else if (m_rsp_valid)             outst_q <= 1'b0;
   end

   assign idle    = !m_req_valid && !outst_q;
   assign ctrl_wr = sl_we && (sl_addr == A_CTRL);

   AST_LAUNCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && idle && (sl_wdata[CTRL_WR_BIT] || !rd_disable)) |=> m_req_valid); // R3

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req_valid && !m_req_ready) |=> (m_req_valid && $stable(m_addr) && $stable(m_wdata)
         && $stable(m_strb) && $stable(m_write) && $stable(m_domain) && $stable(m_master_id))); // R6

   AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && idle && !sl_wdata[CTRL_WR_BIT] && rd_disable) |=> (!m_req_valid && $stable(m_wdata))); // R8

   AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (sl_we && !idle) |=> ($stable(m_addr) && $stable(m_strb) && $stable(m_master_id)
         && $stable(m_domain))); // R9

   AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      outst_q |-> !m_req_valid); // R10

   generate
      if (REG_RDATA) begin : g_ro_reg
         AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(sl_addr) == A_CTRL) |-> !sl_rdata[CTRL_RO_BIT]); // R5
      end else begin : g_ro_comb
         AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (sl_addr == A_CTRL) |-> !sl_rdata[CTRL_RO_BIT]); // R5
      end
   endgenerate
endmodule

bind mmio_bus_proxy mbp_checker #(
   .DATA_W   (DATA_W),
   .REG_AW   (REG_AW),
   .REG_RDATA(REG_RDATA)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_disable (rd_disable),
   .sl_we      (sl_we),
   .sl_addr    (sl_addr),
   .sl_wdata   (sl_wdata),
   .sl_rdata   (sl_rdata),
   .m_req_valid(m_req_valid),
   .m_req_ready(m_req_ready),
   .m_addr     (m_addr),
   .m_wdata    (m_wdata),
   .m_strb     (m_strb),
   .m_write    (m_write),
   .m_domain   (m_domain),
   .m_master_id(m_master_id),
   .m_rsp_valid(m_rsp_valid)
);

// File: tb/mmio_bus_proxy_tb_top.sv
module mmio_bus_proxy_tb_top;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_disable = 1'b0;
   logic          sl_we = 1'b0;
   logic [AW-1:0] sl_addr = '0;
   logic [DW-1:0] sl_wdata = '0;
   logic [DW-1:0] sl_rdata;
   logic          m_req_valid;
   logic          m_req_ready = 1'b0;
   logic [DW-1:0] m_addr, m_wdata;
   logic [3:0]    m_strb;
   logic          m_write;
   logic [1:0]    m_domain;
   logic [5:0]    m_master_id;
   logic          m_rsp_valid = 1'b0;
   logic [DW-1:0] m_rsp_rdata = '0;

   always #2.5 clk = ~clk;

   mmio_bus_proxy #(.DATA_W(DW), .REG_AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_disable(rd_disable),
      .sl_we(sl_we), .sl_addr(sl_addr), .sl_wdata(sl_wdata), .sl_rdata(sl_rdata),
      .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_strb(m_strb), .m_write(m_write),
      .m_domain(m_domain), .m_master_id(m_master_id),
      .m_rsp_valid(m_rsp_valid), .m_rsp_rdata(m_rsp_rdata)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [3:0]  strb;
      logic        wr;
      logic [1:0]  dom;
      logic [5:0]  id;
   } req_t;

   req_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   int          ready_delay = 0;
   int          rsp_delay = 1;
   logic [31:0] rsp_word = 32'h0;
   int          rsp_sent = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // responder: drives ready and response pulses at the falling edge
   initial begin
      int rcnt = 0;
      int pcnt = 0;
      bit pend = 1'b0;
      forever begin
         @(negedge clk);
         m_rsp_valid = 1'b0;
         if (m_req_ready) begin
            m_req_ready = 1'b0;
            pend = 1'b1;
            pcnt = 0;
            rcnt = 0;
         end else if (m_req_valid) begin
            if (rcnt >= ready_delay) m_req_ready = 1'b1;
            else rcnt++;
         end else if (pend) begin
            if (pcnt >= rsp_delay) begin
               m_rsp_valid = 1'b1;
               m_rsp_rdata = rsp_word;
               pend = 1'b0;
               rsp_sent++;
            end else pcnt++;
         end
      end
   end

   // monitor: pops the expected request when one appears, checks it is held (R4, R6)
   initial begin
      bit   was_v = 1'b0;
      req_t held = '0;
      forever begin
         @(negedge clk);
         if (m_req_valid) begin
            req_t got;
            got = '{m_addr, m_wdata, m_strb, m_write, m_domain, m_master_id};
            if (!was_v) begin
               if (exp_q.size() == 0) begin
                  checks++; errors++;
                  $display("FAIL R9/R10 unexpected request: actual %h expected none", got);
               end else begin
                  req_t e;
                  e = exp_q.pop_front();
                  chk("R4 addr",   got.addr, e.addr);
                  chk("R4 wdata",  got.wdata, e.wdata);
                  chk("R4 strb",   32'(got.strb), 32'(e.strb));
                  chk("R4 write",  32'(got.wr), 32'(e.wr));
                  chk("R4 domain", 32'(got.dom), 32'(e.dom));
                  chk("R4 id",     32'(got.id), 32'(e.id));
               end
               held = got;
            end else begin
               chk("R6 hold", 32'(got != held), 32'h0);
            end
         end
         was_v = m_req_valid;
      end
   end

   task automatic wr_reg(input int off, input logic [31:0] d);
      @(negedge clk);
      sl_we = 1'b1; sl_addr = AW'(off); sl_wdata = d;
      @(negedge clk);
      sl_we = 1'b0;
   endtask

   task automatic rd_reg(input int off, output logic [31:0] d);
      @(negedge clk);
      sl_addr = AW'(off);
      #1 d = sl_rdata;
   endtask

   // driver: loads the registers, pushes the expected request, then launches
   task automatic issue(input logic [31:0] a, input logic [31:0] d, input logic [31:0] c,
                        input bit expect_req);
      wr_reg(0, a);
      wr_reg(4, d);
      if (expect_req)
         exp_q.push_back('{a, d, c[6:3], c[0], c[2:1], c[30:25]});
      wr_reg(8, c);
   endtask

   task automatic wait_rsp(input int n);
      int guard = 0;
      while (rsp_sent < n && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int          n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_reg(0, v); chk("R1 addr reset", v, 32'h0);
      rd_reg(4, v); chk("R1 data reset", v, 32'h0);
      rd_reg(8, v); chk("R1 ctrl reset", v, 32'h0);
      chk("R1 no request", 32'(m_req_valid), 32'h0);

      // R2 register map, unmapped offset reads zero
      wr_reg(0, 32'h1234_5678);
      wr_reg(4, 32'hCAFE_F00D);
      rd_reg(0, v); chk("R2 addr reg", v, 32'h1234_5678);
      rd_reg(4, v); chk("R2 data reg", v, 32'hCAFE_F00D);
      rd_reg(12, v); chk("R2 unmapped", v, 32'h0);

      // R3/R4/R5 write with bit31 set, lane 0 only, secure, id 0x2A
      n = rsp_sent;
      issue(32'h0000_1000, 32'hA5A5_0001, 32'h8000_0000 | (32'h2A << 25) | (32'h1 << 3) | 32'h1, 1'b1);
      chk("R3 request next cycle", 32'(m_req_valid), 32'h1);
      wait_rsp(n + 1);
      rd_reg(8, v); chk("R5 bit31 reads zero", v, (32'h2A << 25) | (32'h1 << 3) | 32'h1);
      rd_reg(4, v); chk("R7 write keeps data", v, 32'hA5A5_0001);

      // R4 lane 3 only, non-secure domain, id 0x3F; then alternate domain, lanes 1 and 2
      n = rsp_sent;
      issue(32'hE000_0040, 32'h1111_2222, (32'h3F << 25) | (32'h8 << 3) | (32'h2 << 1) | 32'h1, 1'b1);
      wait_rsp(n + 1);
      n = rsp_sent;
      issue(32'h0000_0004, 32'h3333_4444, (32'h01 << 25) | (32'h6 << 3) | (32'h1 << 1) | 32'h1, 1'b1);
      wait_rsp(n + 1);

      // R7 read: preload marker, poll until it changes
      n = rsp_sent;
      rsp_word = 32'h0BAD_F00D;
      rsp_delay = 3;
      issue(32'h0000_2000, 32'hDEAD_BABE, (32'h05 << 25) | (32'hF << 3), 1'b1);
      begin
         int guard = 0;
         v = 32'hDEAD_BABE;
         while (v == 32'hDEAD_BABE && guard < 200) begin
            rd_reg(4, v);
            guard++;
         end
      end
      chk("R7 read result captured", v, 32'h0BAD_F00D);
      wait_rsp(n + 1);

      // R8 read blocked while disabled
      rd_disable = 1'b1;
      n = rsp_sent;
      issue(32'h0000_3000, 32'h5555_AAAA, 32'h0 | (32'hF << 3), 1'b0);
      repeat (20) @(negedge clk);
      chk("R8 read suppressed", 32'(rsp_sent - n), 32'h0);
      rd_reg(4, v); chk("R8 data unchanged", v, 32'h5555_AAAA);
      // R8 write still launches
      issue(32'h0000_3004, 32'h7777_8888, (32'h3 << 3) | 32'h1, 1'b1);
      wait_rsp(n + 1);
      chk("R8 write still launched", 32'(rsp_sent - n), 32'h1);
      rd_disable = 1'b0;

      // R9 writes while outstanding are dropped
      ready_delay = 10;
      n = rsp_sent;
      issue(32'h0000_4000, 32'h9999_0000, (32'h11 << 25) | (32'h5 << 3) | 32'h1, 1'b1);
      wr_reg(0, 32'hFFFF_0000);
      wr_reg(4, 32'hFFFF_1111);
      wr_reg(8, (32'h22 << 25) | (32'hA << 3) | 32'h1);
      wait_rsp(n + 1);
      ready_delay = 0;
      rd_reg(0, v); chk("R9 addr kept", v, 32'h0000_4000);
      rd_reg(4, v); chk("R9 data kept", v, 32'h9999_0000);
      rd_reg(8, v); chk("R9 ctrl kept", v, (32'h11 << 25) | (32'h5 << 3) | 32'h1);

      // R10 no further request without a new control write
      repeat (15) @(negedge clk);
      chk("R10 valid low after completion", 32'(m_req_valid), 32'h0);
      chk("R10 single response", 32'(rsp_sent - n), 32'h1);
      chk("R9 no leftover expected request", 32'(exp_q.size()), 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule